// File: doc/BRIEF.md
# Hibernation Entry and Wake Sequencer

This block is a small always-on controller that decides when a low-power domain goes into hibernation and when it comes back. There are two ways in. Software can set a request bit. The block also enters on its own when main power is lost while the battery supply is still valid. While the block is hibernating, it drives an active-high output that tells an external regulator to keep main power off.

A wake happens when any enabled wake source fires. The wake sources are an external wake pin, a reset pin, a group of GPIO lines that each have their own enable, and a match pulse from a real-time counter. After a wake, the block releases the regulator output. It then waits in a waking state until main power reports good, and returns to run. The main domain's power-on reset follows from that point, so the full resume latency is the wake time plus the reset time. A low-battery flag can block entry or block wake, and each of those vetoes has its own configuration bit. A sticky cause register records which enabled sources were active at the moment of wake.

Analog supply and battery detection are done outside this block and reach it as digital levels that are already synchronous to `clk`.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After synchronous reset, `pwr_state` is 0 (run), `regulator_off` is 0, `req_pending` is 0 and `wake_cause` is 0.
- R2: A `req_set` pulse in run sets `req_pending` on the next cycle. One cycle later the block is in hibernate (`pwr_state` = 1), and `req_pending` reads 0 from that same cycle.
- R3: In run, if `main_pwr_ok` is 0 and `batt_ok` is 1, the block enters hibernate on the next cycle with no request. If `batt_ok` is 0, it stays in run.
- R4: `regulator_off` is 1 exactly while `pwr_state` is 1 (hibernate). It is 0 in run (0) and in waking (2).
- R5: In hibernate, any wake source whose bit in `wake_en` is set and whose input is active moves the block to waking (`pwr_state` = 2) on the next cycle. A source whose enable bit is clear has no effect. The `wake_en` bit positions are 0 wake pin, 1 reset pin, 2 GPIO group and 3 counter match.
- R6: The GPIO group counts as active only when at least one line has both `gpio_in[i]` and `gpio_wake_en[i]` set.
- R7: When `block_entry_low` and `batt_low` are both 1, neither entry path is taken and `req_pending` stays 1. Entry proceeds once `batt_low` falls.
- R8: When `block_wake_low` and `batt_low` are both 1, the block stays in hibernate even if enabled sources fire, and `wake_cause` does not change.
- R9: On the hibernate-to-waking step, `wake_cause` (same bit positions as `wake_en`) takes on every enabled active source. It holds its value until a `cause_clr` pulse sets it to 0. If a capture and a clear happen in the same cycle, the result is the new capture only.
- R10: The block stays in waking while `main_pwr_ok` is 0. It returns to run on the cycle after `main_pwr_ok` is 1.
- R11: A `req_set` pulse while the block is not in run is ignored, and `req_pending` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | 1 | Software pulse that sets the hibernate request |
| main_pwr_ok | input | 1 | Main supply is present and good |
| batt_ok | input | 1 | Battery supply is valid |
| batt_low | input | 1 | Battery is below the low threshold |
| block_entry_low | input | 1 | Low battery blocks entry |
| block_wake_low | input | 1 | Low battery blocks wake |
| wake_en | input | 4 | Per-source wake enables (0 pin, 1 reset pin, 2 GPIO, 3 counter) |
| gpio_wake_en | input | GPIO_W | Per-line GPIO wake enables |
| wake_pin | input | 1 | External wake pin level |
| reset_pin | input | 1 | External reset pin level |
| gpio_in | input | GPIO_W | GPIO line levels |
| rtc_match | input | 1 | Counter match pulse |
| cause_clr | input | 1 | Pulse that clears the wake cause |
| regulator_off | output | 1 | Holds the external regulator off during hibernate |
| pwr_state | output | 2 | 0 run, 1 hibernate, 2 waking |
| req_pending | output | 1 | Hibernate request is outstanding |
| wake_cause | output | 4 | Sticky wake cause, same bits as `wake_en` |

## Verification
The assertions assume that every input is already synchronous to `clk` and that `main_pwr_ok` is high when the block leaves reset, so the power-loss path does not fire during reset. They also assume the enable and veto configuration is held steady across each transition being checked. The bench sets configuration only between clock edges and keeps it stable until the checked edge has passed. It raises wake and supply inputs for whole cycles, and it restores `main_pwr_ok` before each reset.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;

    localparam int SRC_W    = 4;
    localparam int SRC_PIN  = 0;
    localparam int SRC_RST  = 1;
    localparam int SRC_GPIO = 2;
    localparam int SRC_RTC  = 3;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HIB  = 2'd1,
        ST_WAKE = 2'd2
    } pwr_state_t;

    typedef struct packed {
        logic block_entry;
        logic block_wake;
    } veto_cfg_t;

    function automatic logic low_batt_veto(input logic enable, input logic low);
        return enable & low;
    endfunction

endpackage

// File: rtl/swc_wake_gate.sv
module swc_wake_gate
    import sleep_wake_pkg::*;
#(
    parameter int GPIO_W = 4
) (
    input  logic [SRC_W-1:0]  src_en,
    input  logic [GPIO_W-1:0] gpio_en,
    input  logic              wake_pin,
    input  logic              reset_pin,
    input  logic [GPIO_W-1:0] gpio_in,
    input  logic              rtc_match,
    output logic [SRC_W-1:0]  hits,
    output logic              wake_any
);

    logic [GPIO_W-1:0] gpio_hit;
    logic [SRC_W-1:0]  raw;

    for (genvar g = 0; g < GPIO_W; g++) begin : g_gpio
        assign gpio_hit[g] = gpio_in[g] & gpio_en[g];
    end

    always_comb begin
        raw           = '0;
        raw[SRC_PIN]  = wake_pin;
        raw[SRC_RST]  = reset_pin;
        raw[SRC_GPIO] = |gpio_hit;
        raw[SRC_RTC]  = rtc_match;
    end

    assign hits     = raw & src_en;
    assign wake_any = |hits;

    // R6: a GPIO hit needs a line that is both active and enabled
    always_comb begin
        if (hits[SRC_GPIO]) begin
            p_gpio_line_r6: assert ((gpio_in & gpio_en) != '0);
        end
    end

endmodule

// File: rtl/swc_entry_arb.sv
module swc_entry_arb
    import sleep_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_run,
    input  logic      req_set,
    input  logic      main_pwr_ok,
    input  logic      batt_ok,
    input  logic      batt_low,
    input  veto_cfg_t veto,
    output logic      req_q,
    output logic      enter_go
);

    logic power_lost;
    logic blocked;

    assign power_lost = !main_pwr_ok && batt_ok;
    assign blocked    = low_batt_veto(veto.block_entry, batt_low);
    assign enter_go   = in_run && (req_q || power_lost) && !blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else if (enter_go) begin
            req_q <= 1'b0;
        end else if (req_set && in_run) begin
            req_q <= 1'b1;
        end
    end

    // R11: outside run a clear request stays clear
    p_req_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (!in_run && !req_q) |=> !req_q);

endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
    import sleep_wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enter_go,
    input  logic             wake_any,
    input  logic [SRC_W-1:0] hits,
    input  logic             batt_low,
    input  veto_cfg_t        veto,
    input  logic             main_pwr_ok,
    input  logic             cause_clr,
    output pwr_state_t       state,
    output logic [SRC_W-1:0] cause
);

    pwr_state_t state_nx;
    logic       wake_go;

    assign wake_go = (state == ST_HIB) && wake_any
                     && !low_batt_veto(veto.block_wake, batt_low);

    always_comb begin
        state_nx = state;
        case (state)
            ST_RUN:  if (enter_go)    state_nx = ST_HIB;
            ST_HIB:  if (wake_go)     state_nx = ST_WAKE;
            ST_WAKE: if (main_pwr_ok) state_nx = ST_RUN;
            default:                  state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            cause <= '0;
        end else begin
            state <= state_nx;
            cause <= (cause_clr ? '0 : cause) | (wake_go ? hits : '0);
        end
    end

    // R5: no enabled source means hibernate holds
    p_stay_hib_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIB && !wake_any) |=> state == ST_HIB);

    // R8: low-battery wake veto keeps hibernate
    p_wake_veto_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIB && veto.block_wake && batt_low) |=> state == ST_HIB);

    // R10: power good in waking returns to run
    p_waking_exit_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE && main_pwr_ok) |=> state == ST_RUN);

    // R9: cause cannot move outside hibernate unless cleared
    p_cause_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_HIB && !cause_clr) |=> $stable(cause));

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import sleep_wake_pkg::*;
#(
    parameter int GPIO_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_set,
    input  logic              main_pwr_ok,
    input  logic              batt_ok,
    input  logic              batt_low,
    input  logic              block_entry_low,
    input  logic              block_wake_low,
    input  logic [SRC_W-1:0]  wake_en,
    input  logic [GPIO_W-1:0] gpio_wake_en,
    input  logic              wake_pin,
    input  logic              reset_pin,
    input  logic [GPIO_W-1:0] gpio_in,
    input  logic              rtc_match,
    input  logic              cause_clr,
    output logic              regulator_off,
    output logic [1:0]        pwr_state,
    output logic              req_pending,
    output logic [SRC_W-1:0]  wake_cause
);

    veto_cfg_t        veto;
    pwr_state_t       state;
    logic [SRC_W-1:0] hits;
    logic             wake_any;
    logic             enter_go;

    assign veto.block_entry = block_entry_low;
    assign veto.block_wake  = block_wake_low;

    swc_wake_gate #(.GPIO_W(GPIO_W)) u_gate (
        .src_en   (wake_en),
        .gpio_en  (gpio_wake_en),
        .wake_pin (wake_pin),
        .reset_pin(reset_pin),
        .gpio_in  (gpio_in),
        .rtc_match(rtc_match),
        .hits     (hits),
        .wake_any (wake_any)
    );

    swc_entry_arb u_entry (
        .clk        (clk),
        .rst        (rst),
        .in_run     (state == ST_RUN),
        .req_set    (req_set),
        .main_pwr_ok(main_pwr_ok),
        .batt_ok    (batt_ok),
        .batt_low   (batt_low),
        .veto       (veto),
        .req_q      (req_pending),
        .enter_go   (enter_go)
    );

    swc_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enter_go   (enter_go),
        .wake_any   (wake_any),
        .hits       (hits),
        .batt_low   (batt_low),
        .veto       (veto),
        .main_pwr_ok(main_pwr_ok),
        .cause_clr  (cause_clr),
        .state      (state),
        .cause      (wake_cause)
    );

    assign pwr_state     = state;
    assign regulator_off = (state == ST_HIB);

    // R3: power loss on battery enters hibernate unless vetoed
    p_power_loss_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !main_pwr_ok && batt_ok
         && !(block_entry_low && batt_low)) |=> state == ST_HIB);

    // R7: entry veto keeps run
    p_entry_veto_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && block_entry_low && batt_low) |=> state == ST_RUN);

    // R2: request is gone once hibernate is reached
    p_req_cleared_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIB && $past(state) == ST_RUN) |-> !req_pending);

endmodule

// File: tb/sleep_wake_ctrl_test.sv
module sleep_wake_ctrl_test;

    localparam int GW = 4;

    typedef struct packed {
        logic [3:0] wen;
        logic [3:0] gen;
        logic       pin;
        logic       rpin;
        logic       rtc;
        logic [3:0] gpio;
        logic       blow;
        logic       vwake;
        logic       woke;
        logic [3:0] cause;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'b0001, 4'b0000, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0001},
        '{4'b0010, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0010},
        '{4'b1000, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b1000},
        '{4'b0111, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000},
        '{4'b0100, 4'b0010, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b0, 1'b0, 1'b0, 4'b0000},
        '{4'b0100, 4'b0010, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b0, 1'b1, 4'b0100},
        '{4'b1111, 4'b1111, 1'b1, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b1001},
        '{4'b0001, 4'b0000, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0000},
        '{4'b0001, 4'b0000, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, 4'b0001},
        '{4'b0100, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_set = 1'b0;
    logic          main_pwr_ok = 1'b1;
    logic          batt_ok = 1'b0;
    logic          batt_low = 1'b0;
    logic          block_entry_low = 1'b0;
    logic          block_wake_low = 1'b0;
    logic [3:0]    wake_en = '0;
    logic [GW-1:0] gpio_wake_en = '0;
    logic          wake_pin = 1'b0;
    logic          reset_pin = 1'b0;
    logic [GW-1:0] gpio_in = '0;
    logic          rtc_match = 1'b0;
    logic          cause_clr = 1'b0;
    logic          regulator_off;
    logic [1:0]    pwr_state;
    logic          req_pending;
    logic [3:0]    wake_cause;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sleep_wake_ctrl #(.GPIO_W(GW)) uut (
        .clk            (clk),
        .rst            (rst),
        .req_set        (req_set),
        .main_pwr_ok    (main_pwr_ok),
        .batt_ok        (batt_ok),
        .batt_low       (batt_low),
        .block_entry_low(block_entry_low),
        .block_wake_low (block_wake_low),
        .wake_en        (wake_en),
        .gpio_wake_en   (gpio_wake_en),
        .wake_pin       (wake_pin),
        .reset_pin      (reset_pin),
        .gpio_in        (gpio_in),
        .rtc_match      (rtc_match),
        .cause_clr      (cause_clr),
        .regulator_off  (regulator_off),
        .pwr_state      (pwr_state),
        .req_pending    (req_pending),
        .wake_cause     (wake_cause)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic clear_inputs();
        req_set = 0; main_pwr_ok = 1; batt_ok = 0; batt_low = 0;
        block_entry_low = 0; block_wake_low = 0; wake_en = '0;
        gpio_wake_en = '0; wake_pin = 0; reset_pin = 0; gpio_in = '0;
        rtc_match = 0; cause_clr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick();
        do_reset();
        // R1 reset state
        check("R1 state", 8'(pwr_state), 8'd0);
        check("R1 regulator_off", 8'(regulator_off), 8'd0);
        check("R1 req_pending", 8'(req_pending), 8'd0);
        check("R1 wake_cause", 8'(wake_cause), 8'd0);

        // vector table: enter by request, apply sources for one cycle
        for (int i = 0; i < NV; i++) begin
            clear_inputs();
            do_reset();
            wake_en = VECS[i].wen;
            gpio_wake_en = VECS[i].gen;
            batt_low = VECS[i].blow;
            block_wake_low = VECS[i].vwake;
            req_set = 1;
            tick();
            req_set = 0;
            tick();
            wake_pin = VECS[i].pin;
            reset_pin = VECS[i].rpin;
            rtc_match = VECS[i].rtc;
            gpio_in = VECS[i].gpio;
            tick();
            // R5 R6 R8 wake decision; R9 captured cause
            check($sformatf("R5/R6/R8 vec%0d state", i), 8'(pwr_state),
                  VECS[i].woke ? 8'd2 : 8'd1);
            check($sformatf("R9 vec%0d cause", i), 8'(wake_cause), 8'(VECS[i].cause));
            clear_inputs();
        end

        // R2 request timing and self-clear, R4 output
        clear_inputs();
        do_reset();
        req_set = 1;
        tick();
        req_set = 0;
        check("R2 pending", 8'(req_pending), 8'd1);
        check("R2 still run", 8'(pwr_state), 8'd0);
        tick();
        check("R2 hibernate", 8'(pwr_state), 8'd1);
        check("R2 self-clear", 8'(req_pending), 8'd0);
        check("R4 off in hib", 8'(regulator_off), 8'd1);

        // R11 request ignored in hibernate
        req_set = 1;
        tick();
        req_set = 0;
        check("R11 ignored", 8'(req_pending), 8'd0);

        // R5 disabled source ignored
        wake_pin = 1;
        tick();
        check("R5 disabled", 8'(pwr_state), 8'd1);
        main_pwr_ok = 0;
        wake_en = 4'b0001;
        tick();
        check("R5 wake", 8'(pwr_state), 8'd2);
        check("R4 released", 8'(regulator_off), 8'd0);
        wake_pin = 0;
        tick();
        check("R10 hold waking", 8'(pwr_state), 8'd2);
        main_pwr_ok = 1;
        tick();
        check("R10 back to run", 8'(pwr_state), 8'd0);
        check("R9 sticky", 8'(wake_cause), 8'd1);

        // R9 capture and clear together
        req_set = 1;
        tick();
        req_set = 0;
        tick();
        wake_en = 4'b0010;
        reset_pin = 1;
        cause_clr = 1;
        tick();
        reset_pin = 0;
        cause_clr = 0;
        check("R9 capture over clear", 8'(wake_cause), 8'd2);
        tick();
        cause_clr = 1;
        tick();
        cause_clr = 0;
        check("R9 clear", 8'(wake_cause), 8'd0);

        // R3 power loss entry
        clear_inputs();
        do_reset();
        main_pwr_ok = 0;
        tick();
        check("R3 no battery", 8'(pwr_state), 8'd0);
        batt_ok = 1;
        tick();
        check("R3 battery entry", 8'(pwr_state), 8'd1);

        // R7 entry veto
        clear_inputs();
        do_reset();
        block_entry_low = 1;
        batt_low = 1;
        req_set = 1;
        tick();
        req_set = 0;
        tick();
        check("R7 blocked", 8'(pwr_state), 8'd0);
        check("R7 pending kept", 8'(req_pending), 8'd1);
        batt_low = 0;
        tick();
        check("R7 entry after", 8'(pwr_state), 8'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule